// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Register

This block keeps the eight-bit status register of a serial flash device and decides, for every command that the front-end parser has already decoded, whether the command may proceed. It sees one command event per cycle: read status, write status, write enable, write disable, program, sector erase or bulk erase. It also sees a completion strobe that the memory array raises when a program, erase or status-write cycle has finished. The status byte is always present on an output for the serial shifter to send out. Every state-changing command gets a one-cycle accept or reject pulse in the cycle after it arrives.

The register tracks a busy flag and a write-enable latch. It holds the protection settings: a protect level, a top/bottom selector, and a bit that, together with an external active-low write-protect pin, freezes the protection settings. Program and sector erase commands are refused when their target sector falls inside the protected region. Bulk erase is refused unless the protect level is zero. The non-volatile bits are ordinary flops here. They take their value from an initial-value input while reset is held. Readback has a single path, so the protocol mode used to shift the byte out has no effect on it.

Top module: `flash_status_ctrl`

## Requirements
- R1: `status_byte` bit 7..0 is {SRWD, BP3, TB, BP2, BP1, BP0, WEL, WIP}. While `rst_n` is low, bits 7..2 load `nv_init[5:0]` in that same order and WEL and WIP clear. Reset is synchronous.
- R2: An accepted write-status, program, sector-erase or bulk-erase command raises `cmd_accept` in the next cycle, and WIP reads 1 from that cycle on.
- R3: A `done_strobe` while WIP is 1 clears both WIP and WEL in the next cycle. A `done_strobe` while WIP is 0 changes nothing.
- R4: While WEL is 0, write-status, program, sector-erase and bulk-erase commands are rejected (`cmd_reject` pulses in the next cycle).
- R5: While WIP is 1, every command except read status and no-op is rejected and leaves the status byte unchanged, apart from the effect of R3.
- R6: An accepted write-status command loads `cmd_wr_bits[5:0]` into status bits 7..2 in the order {SRWD, BP3, TB, BP2, BP1, BP0}.
- R7: When SRWD is 1 and `wp_n` is 0, a write-status command is rejected and bits 7..2 keep their values.
- R8: Bulk erase is accepted only when BP = {BP3,BP2,BP1,BP0} is 0. Otherwise it is rejected.
- R9: Let n be the BP value. The protected sector count is 0 for n = 0. Otherwise it is 2^(n-1), capped at the total sector count. With TB = 0 the protected sectors are the highest-numbered ones; with TB = 1 they are the lowest-numbered ones. A program or sector erase whose `cmd_sector` is protected is rejected.
- R10: Status bits 7..2 change only through an accepted write-status command.
- R11: When WIP is 0, write enable is accepted and sets WEL, and write disable is accepted and clears WEL.
- R12: The `cmd_op` encoding is 0 read status, 1 write status, 2 write enable, 3 write disable, 4 program, 5 sector erase, 6 bulk erase, 7 no-op. Read status and no-op raise neither pulse and change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; loads the non-volatile bits |
| nv_init | input | 6 | Values for status bits 7..2 that load during reset |
| wp_n | input | 1 | External write-protect pin, active low |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 3 | Command code (see R12) |
| cmd_sector | input | SEC_IDX_W (8) | Target sector of a program or sector erase |
| cmd_wr_bits | input | 6 | New values for status bits 7..2 on a write status |
| done_strobe | input | 1 | The array has finished its current cycle |
| status_byte | output | 8 | Current status register contents |
| cmd_accept | output | 1 | Pulse: the previous cycle's command was accepted |
| cmd_reject | output | 1 | Pulse: the previous cycle's command was rejected |

## Verification
The assertions check these rules on every cycle: the rejection rules for a clear write-enable latch, for a busy device, for the hardware freeze, for bulk erase and for protected sectors; the busy flag rising after an accepted cycle start; completion clearing both WIP and WEL; the non-volatile bits staying stable when no status write is accepted; the quiet response to read and no-op; and accept and reject never pulsing together. Only the bench scenarios can show that the bits loaded by a status write are the right ones. They also show that the protected-sector boundaries are at the right sector for each level and each direction, including the capped all-sectors level. Last, they show that a completion strobe arriving in the same cycle as a command gives the right result.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  typedef enum logic [2:0] {
    OP_RDSR   = 3'd0,
    OP_WRSR   = 3'd1,
    OP_WREN   = 3'd2,
    OP_WRDI   = 3'd3,
    OP_PROG   = 3'd4,
    OP_SERASE = 3'd5,
    OP_BERASE = 3'd6,
    OP_NOP    = 3'd7
  } flash_op_e;

  localparam int IDX_WIP  = 0;
  localparam int IDX_WEL  = 1;
  localparam int IDX_SRWD = 7;
  localparam int IDX_TB   = 5;

  // commands that launch an array or status-write cycle
  function automatic logic op_starts_cycle(flash_op_e op);
    return (op == OP_WRSR) || (op == OP_PROG) ||
           (op == OP_SERASE) || (op == OP_BERASE);
  endfunction

  // commands that receive an accept or reject verdict
  function automatic logic op_is_modifying(flash_op_e op);
    return op_starts_cycle(op) || (op == OP_WREN) || (op == OP_WRDI);
  endfunction

  // protect level from a status byte
  function automatic logic [3:0] bp_of(logic [7:0] sr);
    return {sr[6], sr[4], sr[3], sr[2]};
  endfunction

endpackage

// File: rtl/flash_prot_decode.sv
module flash_prot_decode #(
  parameter int SEC_IDX_W = 8
) (
  input  logic [SEC_IDX_W-1:0] sector,
  input  logic [3:0]           bp,
  input  logic                 tb,
  output logic                 hit
);
  localparam logic [SEC_IDX_W:0] ALL_SEC = {1'b1, {SEC_IDX_W{1'b0}}};
  localparam logic [SEC_IDX_W:0] ONE_SEC = {{SEC_IDX_W{1'b0}}, 1'b1};

  // number of protected sectors for a given protect level
  function automatic logic [SEC_IDX_W:0] prot_count(logic [3:0] lvl);
    logic [SEC_IDX_W:0] cnt;
    if (lvl == 4'd0)
      cnt = '0;
    else if (int'(lvl) - 1 >= SEC_IDX_W)
      cnt = ALL_SEC;
    else
      cnt = ONE_SEC << (lvl - 4'd1);
    return cnt;
  endfunction

  logic [SEC_IDX_W:0] cnt;
  logic [SEC_IDX_W:0] sec_ext;

  always_comb begin
    cnt     = prot_count(bp);
    sec_ext = {1'b0, sector};
    if (tb)
      hit = sec_ext < cnt;
    else
      hit = sec_ext >= (ALL_SEC - cnt);
  end
endmodule

// File: rtl/flash_cmd_gate.sv
module flash_cmd_gate
  import flash_status_pkg::*;
(
  input  logic      cmd_valid,
  input  flash_op_e op,
  input  logic      wip,
  input  logic      wel,
  input  logic      hw_frozen,
  input  logic      bp_zero,
  input  logic      prot_hit,
  output logic      ev_accept,
  output logic      ev_reject
);
  logic ok;

  always_comb begin
    ok = 1'b0;
    unique case (op)
      OP_WREN, OP_WRDI:    ok = 1'b1;
      OP_WRSR:             ok = wel && !hw_frozen;
      OP_PROG, OP_SERASE:  ok = wel && !prot_hit;
      OP_BERASE:           ok = wel && bp_zero;
      default:             ok = 1'b0;
    endcase
    if (wip) ok = 1'b0;
    ev_accept = cmd_valid && op_is_modifying(op) && ok;
    ev_reject = cmd_valid && op_is_modifying(op) && !ok;
  end
endmodule

// File: rtl/flash_status_regs.sv
module flash_status_regs
  import flash_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] nv_init,
  input  logic       ev_accept,
  input  flash_op_e  op,
  input  logic [5:0] wr_bits,
  input  logic       done_strobe,
  output logic [7:0] status,
  output logic       ev_done
);
  logic [5:0] nv_q;
  logic       wel_q;
  logic       wip_q;

  assign ev_done = done_strobe && wip_q;
  assign status  = {nv_q, wel_q, wip_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nv_q  <= nv_init;
      wel_q <= 1'b0;
      wip_q <= 1'b0;
    end else if (ev_done) begin
      wip_q <= 1'b0;
      wel_q <= 1'b0;
    end else if (ev_accept) begin
      unique case (op)
        OP_WREN: wel_q <= 1'b1;
        OP_WRDI: wel_q <= 1'b0;
        OP_WRSR: begin
          nv_q  <= wr_bits;
          wip_q <= 1'b1;
        end
        OP_PROG, OP_SERASE, OP_BERASE: wip_q <= 1'b1;
        default: ;
      endcase
    end
  end

  // R3: completion drops busy and write-enable together
  a_r3_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> (status[IDX_WIP] == 1'b0) && (status[IDX_WEL] == 1'b0));

  // R10: protection bits hold unless a status write is accepted
  a_r10_nv_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_accept && op == OP_WRSR) |=> $stable(status[7:2]));
endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import flash_status_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int SECTOR_W  = 16,
  localparam int SEC_IDX_W = ADDR_W - SECTOR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [5:0]           nv_init,
  input  logic                 wp_n,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [SEC_IDX_W-1:0] cmd_sector,
  input  logic [5:0]           cmd_wr_bits,
  input  logic                 done_strobe,
  output logic [7:0]           status_byte,
  output logic                 cmd_accept,
  output logic                 cmd_reject
);
  flash_op_e  op;
  logic [3:0] bp_lvl;
  logic       hw_frozen;
  logic       prot_hit;
  logic       ev_accept;
  logic       ev_reject;
  logic       ev_done;

  assign op        = flash_op_e'(cmd_op);
  assign bp_lvl    = bp_of(status_byte);
  assign hw_frozen = status_byte[IDX_SRWD] && !wp_n;

  flash_prot_decode #(.SEC_IDX_W(SEC_IDX_W)) u_prot (
    .sector (cmd_sector),
    .bp     (bp_lvl),
    .tb     (status_byte[IDX_TB]),
    .hit    (prot_hit)
  );

  flash_cmd_gate u_gate (
    .cmd_valid (cmd_valid),
    .op        (op),
    .wip       (status_byte[IDX_WIP]),
    .wel       (status_byte[IDX_WEL]),
    .hw_frozen (hw_frozen),
    .bp_zero   (bp_lvl == 4'd0),
    .prot_hit  (prot_hit),
    .ev_accept (ev_accept),
    .ev_reject (ev_reject)
  );

  flash_status_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .nv_init     (nv_init),
    .ev_accept   (ev_accept),
    .op          (op),
    .wr_bits     (cmd_wr_bits),
    .done_strobe (done_strobe),
    .status      (status_byte),
    .ev_done     (ev_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_accept <= 1'b0;
      cmd_reject <= 1'b0;
    end else begin
      cmd_accept <= ev_accept;
      cmd_reject <= ev_reject;
    end
  end

  // R2: an accepted cycle start shows as busy afterwards
  a_r2_start_sets_wip: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && op_starts_cycle(op) |=> cmd_accept && status_byte[IDX_WIP]);

  // R4: no write-enable latch, no cycle start
  a_r4_no_wel_reject: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op_starts_cycle(op) && !status_byte[IDX_WEL] |=> cmd_reject);

  // R5: busy device refuses every modifying command
  a_r5_busy_reject: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op_is_modifying(op) && status_byte[IDX_WIP] |=> cmd_reject);

  // R7: frozen protection refuses status writes
  a_r7_frozen_reject: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op == OP_WRSR && status_byte[IDX_SRWD] && !wp_n |=> cmd_reject);

  // R8: bulk erase needs a zero protect level
  a_r8_bulk_guard: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && op == OP_BERASE && bp_lvl != 4'd0 |=> cmd_reject);

  // R9: protected sectors refuse program and sector erase
  a_r9_region_reject: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (op == OP_PROG || op == OP_SERASE) && prot_hit |=> cmd_reject);

  // R12: read and no-op give no verdict
  a_r12_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !op_is_modifying(op) |=> !cmd_accept && !cmd_reject);

  // R2: verdict pulses never overlap
  a_r2_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_accept, cmd_reject}));
endmodule

// File: tb/flash_status_ctrl_bench.sv
module flash_status_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] nv_init;
  logic       wp_n;
  logic       cmd_valid;
  logic [2:0] cmd_op;
  logic [7:0] cmd_sector;
  logic [5:0] cmd_wr_bits;
  logic       done_strobe;
  logic [7:0] status_byte;
  logic       cmd_accept;
  logic       cmd_reject;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [7:0] m_sr;

  always #5 clk = ~clk;

  flash_status_ctrl u_flash_status_ctrl (
    .clk(clk), .rst_n(rst_n), .nv_init(nv_init), .wp_n(wp_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sector(cmd_sector),
    .cmd_wr_bits(cmd_wr_bits), .done_strobe(done_strobe),
    .status_byte(status_byte), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // protected test in byte-address terms: 256 sectors of 64 KiB
  function automatic bit bench_protected(logic [7:0] sec, logic [7:0] sr);
    longint lvl, span, addr, top;
    lvl  = {sr[6], sr[4], sr[3], sr[2]};
    top  = 64'd1 << 24;
    addr = longint'(sec) * 65536;
    if (lvl == 0) span = 0;
    else if (lvl - 1 >= 8) span = top;
    else span = (64'd1 << (lvl - 1)) * 65536;
    if (sr[5]) return addr < span;
    return addr >= top - span;
  endfunction

  task automatic do_cmd(input logic [2:0] op, input logic [7:0] sec,
                        input logic [5:0] bits, input logic dn, input string tag);
    logic ea, er, ok, busy, modif;
    busy  = m_sr[0];
    modif = (op != 3'd0) && (op != 3'd7);
    ok = 1'b0;
    case (op)
      3'd2, 3'd3: ok = 1'b1;
      3'd1:       ok = m_sr[1] && !(m_sr[7] && !wp_n);
      3'd4, 3'd5: ok = m_sr[1] && !bench_protected(sec, m_sr);
      3'd6:       ok = m_sr[1] && ({m_sr[6], m_sr[4:2]} == 4'd0);
      default:    ok = 1'b0;
    endcase
    if (busy) ok = 1'b0;
    ea = modif && ok;
    er = modif && !ok;
    if (dn && busy) m_sr[1:0] = 2'b00;
    else if (ea) begin
      case (op)
        3'd2: m_sr[1] = 1'b1;
        3'd3: m_sr[1] = 1'b0;
        3'd1: begin m_sr[7:2] = bits; m_sr[0] = 1'b1; end
        default: m_sr[0] = 1'b1;
      endcase
    end
    @(negedge clk);
    cmd_valid = (op != 3'd7) || dn ? 1'b1 : 1'b1;
    cmd_op = op; cmd_sector = sec; cmd_wr_bits = bits; done_strobe = dn;
    @(negedge clk);
    cmd_valid = 1'b0; done_strobe = 1'b0;
    chk({tag, " accept"}, {7'd0, cmd_accept}, {7'd0, ea});
    chk({tag, " reject"}, {7'd0, cmd_reject}, {7'd0, er});
    chk({tag, " status"}, status_byte, m_sr);
  endtask

  task automatic done_only(input string tag);
    do_cmd(3'd7, 8'd0, 6'd0, 1'b1, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; nv_init = 6'b101011; wp_n = 1'b1; cmd_valid = 1'b0;
    cmd_op = 3'd0; cmd_sector = 8'd0; cmd_wr_bits = 6'd0; done_strobe = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_sr = {6'b101011, 2'b00};
    chk("R1 reset", status_byte, 8'hAC);
    chk("R1 reset pulses", {6'd0, cmd_accept, cmd_reject}, 8'd0);

    // clear everything: needs WEL, frozen only when wp_n low
    do_cmd(3'd1, 8'd0, 6'd0, 1'b0, "R4 wrsr without wel");
    do_cmd(3'd2, 8'd0, 6'd0, 1'b0, "R11 wren");
    do_cmd(3'd1, 8'd0, 6'd0, 1'b0, "R2 R6 wrsr clear");
    do_cmd(3'd0, 8'd0, 6'd0, 1'b0, "R12 rdsr while busy");
    do_cmd(3'd2, 8'd0, 6'd0, 1'b0, "R5 wren while busy");
    do_cmd(3'd4, 8'd3, 6'd0, 1'b0, "R5 prog while busy");
    done_only("R3 done");
    done_only("R3 done idle");
    do_cmd(3'd2, 8'd0, 6'd0, 1'b0, "R11 wren");
    do_cmd(3'd3, 8'd0, 6'd0, 1'b0, "R11 wrdi");
    do_cmd(3'd4, 8'd3, 6'd0, 1'b0, "R4 prog without wel");

    // level 1, top: sector 255 only
    do_cmd(3'd2, 8'd0, 6'd0, 1'b0, "R11 wren");
    do_cmd(3'd1, 8'd0, 6'b000001, 1'b0, "R6 wrsr bp1");
    done_only("R3 done");
    do_cmd(3'd2, 8'd0, 6'd0, 1'b0, "R11 wren");
    do_cmd(3'd4, 8'd255, 6'd0, 1'b0, "R9 top edge protected");
    do_cmd(3'd6, 8'd0, 6'd0, 1'b0, "R8 bulk with bp");
    do_cmd(3'd5, 8'd254, 6'd0, 1'b0, "R9 below top edge");
    done_only("R3 done");

    // level 3, bottom: sectors 0..3
    do_cmd(3'd2, 8'd0, 6'd0, 1'b0, "R11 wren");
    do_cmd(3'd1, 8'd0, 6'b001011, 1'b0, "R6 wrsr bottom lvl3");
    done_only("R3 done");
    do_cmd(3'd2, 8'd0, 6'd0, 1'b0, "R11 wren");
    do_cmd(3'd4, 8'd3, 6'd0, 1'b0, "R9 bottom edge protected");
    do_cmd(3'd4, 8'd4, 6'd0, 1'b0, "R9 above bottom edge");
    done_only("R3 done");

    // level 15: everything
    do_cmd(3'd2, 8'd0, 6'd0, 1'b0, "R11 wren");
    do_cmd(3'd1, 8'd0, 6'b011111, 1'b0, "R6 wrsr lvl15");
    done_only("R3 done");
    do_cmd(3'd2, 8'd0, 6'd0, 1'b0, "R11 wren");
    do_cmd(3'd4, 8'd0, 6'd0, 1'b0, "R9 all protected low");
    do_cmd(3'd5, 8'd255, 6'd0, 1'b0, "R9 all protected high");

    // freeze: SRWD set, then wp_n low
    do_cmd(3'd1, 8'd0, 6'b100000, 1'b0, "R6 wrsr srwd");
    done_only("R3 done");
    wp_n = 1'b0;
    do_cmd(3'd2, 8'd0, 6'd0, 1'b0, "R11 wren");
    do_cmd(3'd1, 8'd0, 6'b000111, 1'b0, "R7 frozen wrsr");
    do_cmd(3'd0, 8'd0, 6'd0, 1'b0, "R10 bits held");
    wp_n = 1'b1;
    do_cmd(3'd1, 8'd0, 6'b000000, 1'b0, "R7 unfrozen wrsr");
    do_cmd(3'd2, 8'd0, 6'd0, 1'b1, "R3 done with wren");
    do_cmd(3'd2, 8'd0, 6'd0, 1'b0, "R11 wren");
    do_cmd(3'd6, 8'd0, 6'd0, 1'b0, "R8 bulk allowed");
    done_only("R3 done");

    for (int i = 0; i < 1500; i++) begin
      logic [2:0] op;
      logic [5:0] bits;
      logic dn;
      string tag;
      op = ($urandom % 4 == 0) ? 3'd2 : 3'($urandom % 8);
      bits = 6'($urandom);
      if ($urandom % 2 == 0) bits[4:0] = bits[4:0] & 5'b01000;
      if ($urandom % 3 != 0) bits[5] = 1'b0;
      dn = m_sr[0] ? ($urandom % 3 == 0) : ($urandom % 8 == 0);
      wp_n = ($urandom % 4 != 0);
      case (op)
        3'd1: tag = "R6 rand wrsr";
        3'd4, 3'd5: tag = "R9 rand prog/erase";
        3'd6: tag = "R8 rand bulk";
        3'd2, 3'd3: tag = "R11 rand wel";
        default: tag = "R12 rand quiet";
      endcase
      if (m_sr[0] && op != 3'd0 && op != 3'd7) tag = "R5 rand busy";
      do_cmd(op, 8'($urandom), bits, dn, tag);
    end
    finish_run();
  end
endmodule